// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is the shift stage of a small processor's execute path, and it is purely combinational. It takes a 32-bit operand and performs one of four operations on it: arithmetic right shift, logical left shift, logical right shift or right rotation. The result comes back together with new N, Z, C and V condition flags. The incoming carry and overflow flags are also inputs, so the unit can report the flags that stay unchanged.

The shift length comes from one of two sources. The first is a 5-bit field taken from the instruction. The second is the bottom byte of a 32-bit amount register, which gives lengths from 0 to 255. The block defines the result and the carry for every length:

- A length of zero keeps the carry.
- A length of exactly 32 gives a defined result and carry.
- Lengths above 32 also give a defined result and carry.
- Rotate lengths that are multiples of 32 are handled as a case of their own.

Instruction decode, the register file and pipeline control sit outside the block.

Top module: `shift_flag_unit`

## Requirements
- R1: `op_sel` selects the operation: 0 is arithmetic right, 1 is logical left, 2 is logical right, 3 is rotate right. When `use_reg`=1, the length is taken from the amount register.
- R2: In register mode the length is `len_reg[7:0]` (0 to 255), and `len_reg[31:8]` has no effect on any output.
- R3: For immediate logical left (`use_reg`=0, `op_sel`=1), `imm_len` gives the length 0 to 31. `imm_len`=0 is a plain move: `result` equals `operand` and `c_out` equals `c_in`.
- R4: For immediate arithmetic or logical right, `imm_len` values 1 to 31 are taken as they are, and `imm_len`=0 encodes a length of 32.
- R5: Rotate right always takes its length from `len_reg[7:0]`. `use_reg` and `imm_len` have no effect on it.
- R6: `n_out` equals `result[31]`, and `z_out` is 1 exactly when `result` is zero.
- R7: For a length of 1 to 31, `c_out` is the last bit shifted out. For a register length of 0, `result` equals `operand` and `c_out` equals `c_in`.
- R8: `v_out` always equals `v_in`.
- R9: A logical shift of exactly 32 gives a zero result. `c_out` is `operand[0]` for a left shift and `operand[31]` for a right shift.
- R10: A logical shift of more than 32 gives a zero result with `c_out`=0.
- R11: An arithmetic right shift of 32 or more fills every bit of the result with `operand[31]` and sets `c_out` to `operand[31]`.
- R12: A nonzero rotate length that is a multiple of 32 leaves the value unchanged, with `c_out`=`operand[31]`. Any other nonzero rotate uses the length modulo 32, and `c_out` is the new `result[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to shift or rotate |
| op_sel | input | 2 | Operation code (see R1) |
| use_reg | input | 1 | 1: length from amount register, 0: from immediate field |
| imm_len | input | 5 | Immediate length field |
| len_reg | input | 32 | Amount register; only the bottom byte is used |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Shifted or rotated value |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| v_out | output | 1 | New overflow flag |

## Verification
The checker's properties are evaluated only when every input carries a known value. With unknown inputs, a zero-length or oversized case cannot be identified at the ports. The bench drives every input to a defined value before the first sample and keeps them defined for the whole run. The bench's model also relies on `op_sel` taking only its four codes. Because the field is two bits wide, the stimulus covers exactly those four codes and nothing beyond them.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_ASR = 2'd0,
    OP_LSL = 2'd1,
    OP_LSR = 2'd2,
    OP_ROR = 2'd3
  } shf_op_e;
endpackage

// File: rtl/shf_amount.sv
// Chooses the effective shift length from the instruction field or the
// bottom byte of the amount register, applying the immediate encodings.
module shf_amount #(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  shf_pkg::shf_op_e  op,
  input  logic              use_reg,
  input  logic [IMM_W-1:0]  imm_len,
  input  logic [W-1:0]      len_reg,
  output logic [AMT_W-1:0]  amt
);
  import shf_pkg::*;

  logic from_reg;

  always_comb begin
    from_reg = use_reg || (op == OP_ROR);
    if (from_reg) begin
      amt = len_reg[AMT_W-1:0];
    end else if (op != OP_LSL && imm_len == '0) begin
      amt = AMT_W'(W);
    end else begin
      amt = AMT_W'(imm_len);
    end
  end
endmodule

// File: rtl/shf_rotr.sv
// Logarithmic right rotator: one stage per bit of the rotate count.
module shf_rotr #(
  parameter int W  = 32,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] rk,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [LW+1];

  assign stage[0] = din;

  genvar s;
  generate
    for (s = 0; s < LW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stage[s+1] = rk[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]}
                                : stage[s];
    end
  endgenerate

  assign dout = stage[LW];
endmodule

// File: rtl/shf_core.sv
// Produces result and carry from operand, operation and effective length.
module shf_core #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]      x,
  input  shf_pkg::shf_op_e  op,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              cout
);
  import shf_pkg::*;

  localparam int LW = $clog2(W);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [LW-1:0] k;
  logic [LW-1:0] k_neg;
  logic [LW-1:0] k_m1;
  logic [LW-1:0] rk;
  logic [W-1:0]  rot;
  logic [W-1:0]  mask_lo;
  logic [W-1:0]  mask_hi;
  logic          sign;
  logic          len_zero;
  logic          len_full;
  logic          len_over;

  assign k        = amt[LW-1:0];
  assign k_neg    = ~k + 1'b1;
  assign k_m1     = k - 1'b1;
  assign rk       = (op == OP_LSL) ? k_neg : k;
  assign mask_lo  = ONES >> k;
  assign mask_hi  = ONES << k;
  assign sign     = x[W-1];
  assign len_zero = (amt == '0);
  assign len_full = (amt == AMT_W'(W));
  assign len_over = (amt > AMT_W'(W));

  shf_rotr #(.W(W), .LW(LW)) u_rotr (
    .din  (x),
    .rk   (rk),
    .dout (rot)
  );

  always_comb begin
    res  = x;
    cout = cin;
    if (!len_zero) begin
      unique case (op)
        OP_LSL: begin
          if (len_full) begin
            res  = '0;
            cout = x[0];
          end else if (len_over) begin
            res  = '0;
            cout = 1'b0;
          end else begin
            res  = rot & mask_hi;
            cout = x[rk];
          end
        end
        OP_LSR: begin
          if (len_full) begin
            res  = '0;
            cout = sign;
          end else if (len_over) begin
            res  = '0;
            cout = 1'b0;
          end else begin
            res  = rot & mask_lo;
            cout = x[k_m1];
          end
        end
        OP_ASR: begin
          if (len_full || len_over) begin
            res  = {W{sign}};
            cout = sign;
          end else begin
            res  = (rot & mask_lo) | ({W{sign}} & ~mask_lo);
            cout = x[k_m1];
          end
        end
        OP_ROR: begin
          if (k == '0) begin
            res  = x;
            cout = sign;
          end else begin
            res  = rot;
            cout = rot[W-1];
          end
        end
        default: begin
          res  = x;
          cout = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     operand,
  input  logic [1:0]       op_sel,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_len,
  input  logic [W-1:0]     len_reg,
  input  logic             c_in,
  input  logic             v_in,
  output logic [W-1:0]     result,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             v_out
);
  import shf_pkg::*;

  shf_op_e          op;
  logic [AMT_W-1:0] amt;
  logic [W-1:0]     res_w;
  logic             carry_w;

  assign op = shf_op_e'(op_sel);

  shf_amount #(.W(W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amount (
    .op      (op),
    .use_reg (use_reg),
    .imm_len (imm_len),
    .len_reg (len_reg),
    .amt     (amt)
  );

  shf_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .x    (operand),
    .op   (op),
    .amt  (amt),
    .cin  (c_in),
    .res  (res_w),
    .cout (carry_w)
  );

  assign result = res_w;
  assign n_out  = res_w[W-1];
  assign z_out  = ~|res_w;
  assign c_out  = carry_w;
  assign v_out  = v_in;
endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input logic [W-1:0]     operand,
  input logic [1:0]       op_sel,
  input logic             use_reg,
  input logic [IMM_W-1:0] imm_len,
  input logic [W-1:0]     len_reg,
  input logic             c_in,
  input logic             v_in,
  input logic [W-1:0]     result,
  input logic             n_out,
  input logic             z_out,
  input logic             c_out,
  input logic             v_out
);
  logic known;
  logic reg_path;
  logic zero_len;
  logic logical;

  always_comb begin
    known    = !$isunknown({operand, op_sel, use_reg, imm_len, len_reg, c_in, v_in});
    reg_path = use_reg || (op_sel == 2'd3);
    zero_len = (reg_path && len_reg[7:0] == 8'd0) ||
               (!reg_path && op_sel == 2'd1 && imm_len == '0);
    logical  = (op_sel == 2'd1) || (op_sel == 2'd2);
    if (known) begin
      AST_V_PASSES: assert (v_out == v_in);                                        // R8
      AST_N_IS_MSB: assert (n_out == result[W-1]);                                 // R6
      AST_Z_ON_ZERO: assert (z_out == (result == '0));                             // R6
      AST_ZERO_LEN_HOLDS: assert (!zero_len || (result == operand && c_out == c_in)); // R7
      AST_BIG_LOGICAL_CLEARS: assert (!(reg_path && logical && len_reg[7:0] > 8'd32)
                                      || (result == '0 && !c_out));                // R10
      AST_BIG_ASR_SIGN: assert (!(reg_path && op_sel == 2'd0 && len_reg[7:0] >= 8'd32)
                                || (result == {W{operand[W-1]}} && c_out == operand[W-1])); // R11
    end
  end
endmodule

bind shift_flag_unit shift_flag_unit_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .operand (operand),
  .op_sel  (op_sel),
  .use_reg (use_reg),
  .imm_len (imm_len),
  .len_reg (len_reg),
  .c_in    (c_in),
  .v_in    (v_in),
  .result  (result),
  .n_out   (n_out),
  .z_out   (z_out),
  .c_out   (c_out),
  .v_out   (v_out)
);

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] operand;
  logic [1:0]  op_sel;
  logic        use_reg;
  logic [4:0]  imm_len;
  logic [31:0] len_reg;
  logic        c_in;
  logic        v_in;
  logic [31:0] result;
  logic        n_out;
  logic        z_out;
  logic        c_out;
  logic        v_out;

  int checks;
  int errors;
  bit done;

  shift_flag_unit u_shift_flag_unit (
    .operand (operand),
    .op_sel  (op_sel),
    .use_reg (use_reg),
    .imm_len (imm_len),
    .len_reg (len_reg),
    .c_in    (c_in),
    .v_in    (v_in),
    .result  (result),
    .n_out   (n_out),
    .z_out   (z_out),
    .c_out   (c_out),
    .v_out   (v_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Model: shift one place per step, carry is the bit that leaves.
  function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] x,
                                        input int len, input logic cin);
    logic [31:0] v;
    logic        c;
    v = x;
    c = cin;
    for (int i = 0; i < len; i++) begin
      case (op)
        2'd1: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd2: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd0: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic int eff_len(input logic [1:0] op, input logic ureg,
                                 input logic [4:0] imm, input logic [31:0] lr);
    if (ureg || op == 2'd3) return int'(lr[7:0]);
    if (op != 2'd1 && imm == 5'd0) return 32;
    return int'(imm);
  endfunction

  task automatic apply(input logic [1:0] op, input logic ureg, input logic [4:0] imm,
                       input logic [31:0] lr, input logic [31:0] x, input logic cin,
                       input logic vin, input string tag);
    logic [32:0] exp_cv;
    logic [31:0] exp_r;
    @(negedge clk);
    op_sel = op; use_reg = ureg; imm_len = imm; len_reg = lr;
    operand = x; c_in = cin; v_in = vin;
    exp_cv = model(op, x, eff_len(op, ureg, imm, lr), cin);
    exp_r  = exp_cv[31:0];
    @(posedge clk);
    #2;
    checks++;
    if (result !== exp_r || c_out !== exp_cv[32] || n_out !== exp_r[31] ||
        z_out !== (exp_r == 32'd0) || v_out !== vin) begin
      errors++;
      $display("FAIL %s op=%0d reg=%0b imm=%0d len=%h x=%h: got r=%h n%b z%b c%b v%b exp r=%h n%b z%b c%b v%b",
               tag, op, ureg, imm, lr, x, result, n_out, z_out, c_out, v_out,
               exp_r, exp_r[31], exp_r == 32'd0, exp_cv[32], vin);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    #2;
    checks++;
    if (result !== 32'd0 || z_out !== 1'b1 || n_out !== 1'b0 || c_out !== 1'b0 || v_out !== 1'b0) begin
      errors++;
      $display("FAIL R6 idle: got r=%h z%b n%b c%b v%b exp r=0 z1 n0 c0 v0",
               result, z_out, n_out, c_out, v_out);
    end
  endtask

  task automatic t_ops;  // R1 R7
    apply(2'd0, 1'b1, 5'd0, 32'd4,  32'h8000_00F0, 1'b0, 1'b0, "R1 asr");
    apply(2'd1, 1'b1, 5'd0, 32'd3,  32'hF000_0001, 1'b0, 1'b0, "R1 lsl");
    apply(2'd2, 1'b1, 5'd0, 32'd5,  32'h8000_0010, 1'b1, 1'b0, "R1 lsr");
    apply(2'd3, 1'b1, 5'd0, 32'd8,  32'h1234_5678, 1'b0, 1'b0, "R1 ror");
    apply(2'd2, 1'b1, 5'd0, 32'd1,  32'h0000_0001, 1'b0, 1'b0, "R7 last out");
    apply(2'd1, 1'b1, 5'd0, 32'd31, 32'h0000_0003, 1'b0, 1'b0, "R7 lsl31");
    for (int op = 0; op < 4; op++)
      apply(2'(op), 1'b1, 5'd0, 32'd0, 32'hA5A5_0F0F, 1'b1, 1'b0, "R7 zero len");
  endtask

  task automatic t_reg_byte;  // R2
    apply(2'd2, 1'b1, 5'd0, 32'hFFFF_FF04, 32'hF0F0_F0F0, 1'b0, 1'b0, "R2 high bits");
    apply(2'd1, 1'b1, 5'd0, 32'h1234_0000, 32'h8000_0001, 1'b1, 1'b0, "R2 byte zero");
    apply(2'd0, 1'b1, 5'd0, 32'h0000_01FF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R2 byte 255");
  endtask

  task automatic t_imm;  // R3 R4
    apply(2'd1, 1'b0, 5'd0,  32'd77, 32'h8000_0000, 1'b1, 1'b0, "R3 move");
    apply(2'd1, 1'b0, 5'd0,  32'd0,  32'h0000_0000, 1'b0, 1'b1, "R3 move zero");
    apply(2'd1, 1'b0, 5'd31, 32'd0,  32'h0000_0002, 1'b0, 1'b0, "R3 lsl31");
    apply(2'd1, 1'b0, 5'd9,  32'd0,  32'h00C0_0001, 1'b0, 1'b0, "R3 lsl9");
    apply(2'd2, 1'b0, 5'd0,  32'd3,  32'h8000_0000, 1'b0, 1'b0, "R4 lsr32");
    apply(2'd0, 1'b0, 5'd0,  32'd3,  32'h8000_0000, 1'b0, 1'b0, "R4 asr32");
    apply(2'd0, 1'b0, 5'd9,  32'd0,  32'h8765_4321, 1'b0, 1'b0, "R4 asr9");
    apply(2'd2, 1'b0, 5'd1,  32'd0,  32'h0000_0003, 1'b0, 1'b0, "R4 lsr1");
  endtask

  task automatic t_ror_mode;  // R5
    apply(2'd3, 1'b0, 5'd7, 32'd4, 32'h0000_000F, 1'b0, 1'b0, "R5 imm ignored");
    apply(2'd3, 1'b0, 5'd3, 32'd0, 32'h8000_0001, 1'b1, 1'b0, "R5 zero reg");
  endtask

  task automatic t_flags;  // R6 R8
    apply(2'd1, 1'b1, 5'd0, 32'd1, 32'h4000_0000, 1'b0, 1'b1, "R6 negative");
    apply(2'd2, 1'b1, 5'd0, 32'd4, 32'h0000_000F, 1'b0, 1'b1, "R6 zero");
    apply(2'd3, 1'b1, 5'd0, 32'd2, 32'h0000_0001, 1'b1, 1'b0, "R8 v low");
    apply(2'd0, 1'b1, 5'd0, 32'd2, 32'h0000_0001, 1'b0, 1'b1, "R8 v high");
  endtask

  task automatic t_edges;  // R9 R10 R11 R12
    apply(2'd1, 1'b1, 5'd0, 32'd32,  32'h0000_0001, 1'b0, 1'b0, "R9 lsl32");
    apply(2'd2, 1'b1, 5'd0, 32'd32,  32'h8000_0000, 1'b0, 1'b0, "R9 lsr32");
    apply(2'd1, 1'b1, 5'd0, 32'd33,  32'hFFFF_FFFF, 1'b1, 1'b0, "R10 lsl33");
    apply(2'd2, 1'b1, 5'd0, 32'd200, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10 lsr200");
    apply(2'd0, 1'b1, 5'd0, 32'd32,  32'h8000_0000, 1'b0, 1'b0, "R11 asr32");
    apply(2'd0, 1'b1, 5'd0, 32'd100, 32'h7FFF_FFFF, 1'b1, 1'b0, "R11 asr100");
    apply(2'd3, 1'b1, 5'd0, 32'd32,  32'h8000_0001, 1'b0, 1'b0, "R12 ror32");
    apply(2'd3, 1'b1, 5'd0, 32'd64,  32'h7000_0001, 1'b1, 1'b0, "R12 ror64");
    apply(2'd3, 1'b1, 5'd0, 32'd33,  32'h0000_0001, 1'b0, 1'b0, "R12 ror33");
  endtask

  task automatic t_sweep;  // R1 R2 R7 R9 R10 R11 R12
    for (int op = 0; op < 4; op++)
      for (int len = 0; len < 256; len++) begin
        apply(2'(op), 1'b1, 5'd0, {24'h5A5A5A, 8'(len)}, 32'hC3A5_1E69, len[0], len[1], "R2 sweep");
        apply(2'(op), 1'b1, 5'd0, 32'(len), 32'h3C5A_E196, len[1], len[0], "R7 sweep");
      end
    for (int op = 0; op < 3; op++)
      for (int imm = 0; imm < 32; imm++)
        apply(2'(op), 1'b0, 5'(imm), 32'hFFFF_FF11, 32'h9E37_79B9, imm[0], 1'b0, "R4 imm sweep");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    operand = '0; op_sel = '0; use_reg = 1'b0; imm_len = 5'd1;
    len_reg = '0; c_in = 1'b0; v_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ops();
    t_reg_byte();
    t_imm();
    t_ror_mode();
    t_flags();
    t_edges();
    t_sweep();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule